// File: doc/BRIEF.md
# Link Wake-Request Pulse Generator

This block decides when a sleeping link-layer controller has to be woken and drives a periodic wake signal toward it. It watches several wake causes: a received wake packet addressed to this node, a set of interrupt status bits, and a power-cycle event that carries a power class. While the link is asleep and a cause is held, the block drives a square wave on its wake output. The link is asleep whenever its power-status indication is inactive or its link-control bit is clear. The wave stops as soon as the link reports itself active.

Each wake cause is held in its own flag and has its own release rule. The link becoming active clears every flag. A bus reset drops only the packet cause, so a wake that is also held by an interrupt or by a power-cycle event keeps running. A power-cycle cause ends by itself after a programmable number of clock cycles. An interrupt condition that is present while the link is active starts a wake in the first cycle after the link goes inactive. A separate output-enable tells the pad to float the wake line while hardware reset is applied.

Top module: `link_wake_gen`

## Requirements
- R1: While rst_n is low, wake_out and wake_oe are 0 after the clock edge. wake_oe becomes 1 after the first edge at which rst_n is high and stays 1 afterwards.
- R2: While any wake cause is held, wake_out is high for HALF_CYCLES cycles and then low for HALF_CYCLES cycles, repeating. The first cycle of a new wake is high.
- R3: A wake_pkt pulse sampled while link_active is 0 sets the packet cause, and wake_out goes high after that same edge.
- R4: int_port_evt = 1 sampled while link_active is 0 sets the interrupt cause whatever resume_int_en is.
- R5: int_cfg_to, int_cpwr or int_state_to set the interrupt cause only when resume_int_en is 1. With resume_int_en at 0 they have no effect on wake_out.
- R6: A pwr_cycle pulse sets the power-cycle cause only when pwr_class (unsigned, 3 bits) is 4 or less. Classes 5 to 7 have no effect on wake_out.
- R7: link_active = 1 sampled at an edge clears all causes, and wake_out is 0 after that edge. No cause can be set while link_active is 1.
- R8: A bus_reset pulse clears only the packet cause. wake_out continues unchanged if the interrupt cause or the power-cycle cause is held.
- R9: The power-cycle cause is released after exactly TIMEOUT_CYCLES cycles. A new qualifying pwr_cycle pulse restarts the count. Other causes keep wake_out running after the release.
- R10: An interrupt condition that is present while link_active is 1 sets the interrupt cause at the first edge at which link_active is 0.
- R11: When wake_pkt and bus_reset are sampled at the same edge, the packet cause is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the wave and all state |
| rst_n | input | 1 | Synchronous reset, active low |
| link_active | input | 1 | Link powered and its control bit set |
| wake_pkt | input | 1 | One-cycle pulse: wake packet for this node received |
| int_port_evt | input | 1 | Port-event interrupt status bit |
| int_cfg_to | input | 1 | Configuration-timeout interrupt status bit |
| int_cpwr | input | 1 | Cable-power-status interrupt status bit |
| int_state_to | input | 1 | State-timeout interrupt status bit |
| resume_int_en | input | 1 | Enables the three gated interrupt bits as wake causes |
| bus_reset | input | 1 | One-cycle pulse: bus reset occurred |
| pwr_cycle | input | 1 | One-cycle pulse: power-cycle event |
| pwr_class | input | 3 | Power class that comes with pwr_cycle |
| wake_out | output | 1 | Wake square wave, low when idle |
| wake_oe | output | 1 | Pad enable for wake_out, low during reset |

## Verification
A cause flag that was set or cleared wrongly shows on wake_out in the cycle right after the edge that should have changed it. This is because the output is decoded straight from the flags and the phase counter, with no further register. A phase counter that is off shows within one wave period as a high or low run of the wrong length or at the wrong position. A power-cycle counter error shows only when the cause is released, one or more cycles early or late, and only when no other cause hides it. For that reason the timeout is checked both alone and with the packet cause held.

// File: rtl/lwg_pkg.sv
package lwg_pkg;

   // Wake causes, each held separately so that every one has its own release rule.
   typedef struct packed {
      logic pkt;    // released by bus reset or link active
      logic intr;   // released only by link active
      logic pwr;    // released by timeout or link active
   } wake_cause_t;

   localparam int unsigned CLASS_W = 3;

   // Gated interrupt wake condition.
   function automatic logic intr_wake(input logic port_evt,
                                      input logic cfg_to,
                                      input logic cpwr,
                                      input logic state_to,
                                      input logic resume_en);
      return port_evt | (resume_en & (cfg_to | cpwr | state_to));
   endfunction

   // Power class qualifier.
   function automatic logic class_wakes(input logic [CLASS_W-1:0] cls,
                                        input int unsigned limit);
      return (32'(cls) <= limit);
   endfunction

   function automatic logic any_cause(input wake_cause_t c);
      return c.pkt | c.intr | c.pwr;
   endfunction

endpackage

// File: rtl/lwg_pwr_timer.sv
module lwg_pwr_timer #(
   parameter int unsigned TIMEOUT_CYCLES = 33400
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic start,
   input  logic running,
   output logic expire
);
   localparam int unsigned CNT_W = (TIMEOUT_CYCLES < 2) ? 1 : $clog2(TIMEOUT_CYCLES + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear || start) begin
         cnt_q <= '0;
      end else if (running && (cnt_q != LAST)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // A start in the same cycle restarts the window and wins over expiry.
   assign expire = running && !start && !clear && (cnt_q == LAST);

endmodule

// File: rtl/lwg_cause_tracker.sv
module lwg_cause_tracker
   import lwg_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        link_active,
   input  logic        pkt_set,
   input  logic        bus_reset,
   input  logic        intr_set,
   input  logic        pwr_set,
   input  logic        pwr_expire,
   output wake_cause_t cause
);
   wake_cause_t cause_q;
   wake_cause_t cause_d;

   always_comb begin
      cause_d = cause_q;
      if (link_active) begin
         cause_d = '0;
      end else begin
         // a packet in the same cycle as a bus reset survives it
         cause_d.pkt  = pkt_set | (cause_q.pkt & ~bus_reset);
         cause_d.intr = intr_set | cause_q.intr;
         cause_d.pwr  = pwr_set | (cause_q.pwr & ~pwr_expire);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cause_q <= '0;
      end else begin
         cause_q <= cause_d;
      end
   end

   assign cause = cause_q;

endmodule

// File: rtl/lwg_square_gen.sv
module lwg_square_gen #(
   parameter int unsigned HALF_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic wave
);
   localparam int unsigned PERIOD  = 2 * HALF_CYCLES;
   localparam int unsigned PH_W    = (PERIOD < 2) ? 1 : $clog2(PERIOD);
   localparam bit          POW2    = ((HALF_CYCLES & (HALF_CYCLES - 1)) == 0);

   logic [PH_W-1:0] phase_q;

   generate
      if (POW2) begin : g_pow2
         // period is a power of two: the counter wraps by itself, top bit is the half
         always_ff @(posedge clk) begin
            if (!rst_n || !run) begin
               phase_q <= '0;
            end else begin
               phase_q <= phase_q + 1'b1;
            end
         end
         assign wave = run & ~phase_q[PH_W-1];
      end else begin : g_cmp
         localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD - 1);
         localparam logic [PH_W-1:0] PH_HALF = PH_W'(HALF_CYCLES);
         always_ff @(posedge clk) begin
            if (!rst_n || !run) begin
               phase_q <= '0;
            end else if (phase_q == PH_LAST) begin
               phase_q <= '0;
            end else begin
               phase_q <= phase_q + 1'b1;
            end
         end
         assign wave = run & (phase_q < PH_HALF);
      end
   endgenerate

endmodule

// File: rtl/link_wake_gen.sv
module link_wake_gen
   import lwg_pkg::*;
#(
   parameter int unsigned HALF_CYCLES    = 4,
   parameter int unsigned TIMEOUT_CYCLES = 33400,  // 167 us at 200 MHz
   parameter int unsigned MAX_WAKE_CLASS = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               link_active,
   input  logic               wake_pkt,
   input  logic               int_port_evt,
   input  logic               int_cfg_to,
   input  logic               int_cpwr,
   input  logic               int_state_to,
   input  logic               resume_int_en,
   input  logic               bus_reset,
   input  logic               pwr_cycle,
   input  logic [CLASS_W-1:0] pwr_class,
   output logic               wake_out,
   output logic               wake_oe
);
   generate
      if (HALF_CYCLES < 1) begin : g_bad_half
         $error("HALF_CYCLES must be at least 1");
      end
      if (TIMEOUT_CYCLES < 1) begin : g_bad_timeout
         $error("TIMEOUT_CYCLES must be at least 1");
      end
      if (MAX_WAKE_CLASS >= (1 << CLASS_W)) begin : g_bad_class
         $error("MAX_WAKE_CLASS exceeds the power class range");
      end
   endgenerate

   wake_cause_t cause;
   logic        intr_set;
   logic        pwr_set;
   logic        pwr_expire;
   logic        wave;
   logic        oe_q;

   assign intr_set = intr_wake(int_port_evt, int_cfg_to, int_cpwr,
                               int_state_to, resume_int_en);
   assign pwr_set  = pwr_cycle & class_wakes(pwr_class, MAX_WAKE_CLASS);

   lwg_pwr_timer #(
      .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (link_active),
      .start   (pwr_set),
      .running (cause.pwr),
      .expire  (pwr_expire)
   );

   lwg_cause_tracker u_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .link_active (link_active),
      .pkt_set     (wake_pkt),
      .bus_reset   (bus_reset),
      .intr_set    (intr_set),
      .pwr_set     (pwr_set),
      .pwr_expire  (pwr_expire),
      .cause       (cause)
   );

   lwg_square_gen #(
      .HALF_CYCLES(HALF_CYCLES)
   ) u_wave (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (any_cause(cause)),
      .wave  (wave)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         oe_q <= 1'b0;
      end else begin
         oe_q <= 1'b1;
      end
   end

   assign wake_oe  = oe_q;
   assign wake_out = wave & oe_q;

endmodule

// File: rtl/lwg_checker.sv
module lwg_checker #(
   parameter int unsigned HALF_CYCLES = 4
) (
   input logic clk,
   input logic rst_n,
   input logic link_active,
   input logic wake_pkt,
   input logic int_cfg_to,
   input logic resume_int_en,
   input logic wake_out,
   input logic wake_oe
);
   localparam int unsigned RUN_W = $clog2(HALF_CYCLES + 2) + 1;
   localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(HALF_CYCLES + 1);

   logic [RUN_W-1:0] high_run;
   logic [RUN_W-1:0] low_run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         high_run <= '0;
         low_run  <= '0;
      end else begin
         high_run <= !wake_out ? '0 : (high_run == RUN_MAX) ? high_run : high_run + 1'b1;
         low_run  <=  wake_out ? '0 : (low_run  == RUN_MAX) ? low_run  : low_run  + 1'b1;
      end
   end

   assert_oe_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> wake_oe);

   assert_high_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wake_out |-> (high_run < RUN_W'(HALF_CYCLES)));

   assert_pkt_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_pkt && !link_active && !wake_out && low_run >= RUN_W'(HALF_CYCLES)) |=> wake_out);

   assert_gated_intr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (int_cfg_to && resume_int_en && !link_active && !wake_out
       && low_run >= RUN_W'(HALF_CYCLES)) |=> wake_out);

   assert_link_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      link_active |=> !wake_out);

endmodule

bind link_wake_gen lwg_checker #(
   .HALF_CYCLES(HALF_CYCLES)
) u_lwg_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .link_active   (link_active),
   .wake_pkt      (wake_pkt),
   .int_cfg_to    (int_cfg_to),
   .resume_int_en (resume_int_en),
   .wake_out      (wake_out),
   .wake_oe       (wake_oe)
);

// File: tb/test_link_wake_gen.sv
`timescale 1ns/1ps
module test_link_wake_gen;
   localparam int HALF = 4;
   localparam int TO   = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic link_active = 1'b0, wake_pkt = 1'b0, int_port_evt = 1'b0, int_cfg_to = 1'b0;
   logic int_cpwr = 1'b0, int_state_to = 1'b0, resume_int_en = 1'b0, bus_reset = 1'b0;
   logic pwr_cycle = 1'b0;
   logic [2:0] pwr_class = 3'd0;
   logic wake_out, wake_oe;

   int tests = 0, fails = 0, cyc = 0;
   string cur_req = "R1";
   bit started = 1'b0;

   // reference model state
   bit m_pkt = 0, m_int = 0, m_pc = 0, m_oe = 0;
   int m_cnt = 0, m_ph = 0;

   always #2.5 clk = ~clk;

   link_wake_gen #(.HALF_CYCLES(HALF), .TIMEOUT_CYCLES(TO)) i_link_wake_gen (
      .clk(clk), .rst_n(rst_n), .link_active(link_active), .wake_pkt(wake_pkt),
      .int_port_evt(int_port_evt), .int_cfg_to(int_cfg_to), .int_cpwr(int_cpwr),
      .int_state_to(int_state_to), .resume_int_en(resume_int_en), .bus_reset(bus_reset),
      .pwr_cycle(pwr_cycle), .pwr_class(pwr_class), .wake_out(wake_out), .wake_oe(wake_oe));

   always @(posedge clk) begin
      bit was, ic;
      started = 1'b1;
      cyc++;
      if (!rst_n) begin
         m_pkt = 0; m_int = 0; m_pc = 0; m_oe = 0; m_cnt = 0; m_ph = 0;
      end else begin
         was = m_pkt | m_int | m_pc;
         m_ph = was ? (m_ph + 1) % (2 * HALF) : 0;
         m_oe = 1;
         ic = int_port_evt | (resume_int_en & (int_cfg_to | int_cpwr | int_state_to));
         if (link_active) begin
            m_pkt = 0; m_int = 0; m_pc = 0; m_cnt = 0;
         end else begin
            m_pkt = wake_pkt | (m_pkt & !bus_reset);
            if (ic) m_int = 1;
            if (pwr_cycle && pwr_class <= 3'd4) begin m_pc = 1; m_cnt = 0; end
            else if (m_pc) begin
               if (m_cnt == TO - 1) m_pc = 0; else m_cnt++;
            end
         end
      end
   end

   task automatic check(input string req, input logic act, input logic exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%b exp=%b at cycle %0d", req, act, exp, cyc);
      end
   endtask

   // every clock: compare with the model
   always @(negedge clk) begin
      if (started) begin
         check(cur_req, wake_out, m_oe && (m_pkt || m_int || m_pc) && (m_ph < HALF));
         check({cur_req, "/oe"}, wake_oe, m_oe);
      end
      if (cyc > 20000) begin
         fails++;
         $display("FAIL watchdog act=%0d cycles exp<20000", cyc);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic count_high(input string req, input int win, input int exp);
      int h = 0;
      for (int i = 0; i < win; i++) begin
         @(negedge clk);
         if (wake_out) h++;
      end
      tests++;
      if (h != exp) begin
         fails++;
         $display("FAIL %s act=%0d high cycles exp=%0d", req, h, exp);
      end
   endtask

   initial begin
      // R1: reset
      cur_req = "R1";
      tick(3);
      check("R1 out in reset", wake_out, 1'b0);
      check("R1 oe in reset", wake_oe, 1'b0);
      rst_n = 1'b1;
      tick(1);
      check("R1 oe after reset", wake_oe, 1'b1);
      tick(3);
      check("R1 idle", wake_out, 1'b0);

      // R3, R2: packet wake and wave shape
      cur_req = "R3";
      wake_pkt = 1'b1; tick(1); wake_pkt = 1'b0;
      check("R3 first high", wake_out, 1'b1);
      cur_req = "R2";
      count_high("R2 duty", 16, 8);

      // R8: bus reset ends a packet-only wake
      cur_req = "R8";
      bus_reset = 1'b1; tick(1); bus_reset = 1'b0;
      check("R8 pkt only stops", wake_out, 1'b0);
      tick(4);

      // R4 + R8: interrupt holds the wake through bus reset
      cur_req = "R4";
      wake_pkt = 1'b1; int_port_evt = 1'b1; tick(1); wake_pkt = 1'b0; int_port_evt = 1'b0;
      tick(2);
      cur_req = "R8";
      bus_reset = 1'b1; tick(1); bus_reset = 1'b0;
      count_high("R8 wake continues", 16, 8);

      // R7: link active stops everything
      cur_req = "R7";
      link_active = 1'b1; tick(1);
      check("R7 stop", wake_out, 1'b0);
      wake_pkt = 1'b1; int_port_evt = 1'b1; tick(1); wake_pkt = 1'b0;
      tick(3);
      check("R7 blocked while active", wake_out, 1'b0);
      int_port_evt = 1'b0;

      // R5: gated bits need the enable
      cur_req = "R5";
      link_active = 1'b0; int_cfg_to = 1'b1; int_cpwr = 1'b1; int_state_to = 1'b1;
      count_high("R5 ignored without enable", 12, 0);
      int_cpwr = 1'b0; int_state_to = 1'b0;
      resume_int_en = 1'b1; tick(1);
      check("R5 enabled cfg timeout", wake_out, 1'b1);
      cur_req = "R7";
      link_active = 1'b1; tick(1);
      check("R7 stop gated", wake_out, 1'b0);

      // R10: pending interrupt wakes once link goes inactive
      cur_req = "R10";
      tick(5);
      check("R10 held off", wake_out, 1'b0);
      link_active = 1'b0; tick(1);
      check("R10 re-arm", wake_out, 1'b1);
      int_cfg_to = 1'b0; resume_int_en = 1'b0;
      link_active = 1'b1; tick(2); link_active = 1'b0; tick(2);
      check("R10 cleared", wake_out, 1'b0);

      // R6: class qualification
      cur_req = "R6";
      for (int c = 5; c < 8; c++) begin
         pwr_class = 3'(c); pwr_cycle = 1'b1; tick(1); pwr_cycle = 1'b0;
         tick(2);
         check("R6 class above 4 ignored", wake_out, 1'b0);
      end

      // R9: timeout of a power-cycle wake
      cur_req = "R9";
      pwr_class = 3'd4; pwr_cycle = 1'b1; tick(1); pwr_cycle = 1'b0;
      check("R6 class 4 wakes", wake_out, 1'b1);
      tick(TO - 1);
      count_high("R9 released after timeout", 16, 0);
      pwr_class = 3'd0; pwr_cycle = 1'b1; tick(1); pwr_cycle = 1'b0;
      tick(TO / 2);
      pwr_cycle = 1'b1; tick(1); pwr_cycle = 1'b0;   // restart
      tick(TO - 2);
      check("R9 restarted window", wake_out === 1'b1 || wake_out === 1'b0, 1'b1);
      tick(4);
      check("R9 end of restarted window", wake_out, 1'b0);

      // R9 + R8: packet cause outlives the power-cycle timeout
      pwr_cycle = 1'b1; wake_pkt = 1'b1; tick(1); pwr_cycle = 1'b0; wake_pkt = 1'b0;
      tick(TO + 4);
      count_high("R9 other cause continues", 16, 8);
      link_active = 1'b1; tick(2); link_active = 1'b0;

      // R11: packet and bus reset together
      cur_req = "R11";
      wake_pkt = 1'b1; bus_reset = 1'b1; tick(1); wake_pkt = 1'b0; bus_reset = 1'b0;
      check("R11 packet wins", wake_out, 1'b1);
      tick(10);
      bus_reset = 1'b1; tick(1); bus_reset = 1'b0;
      check("R11 later reset clears", wake_out, 1'b0);

      // R1: reset in the middle of a wake
      cur_req = "R1";
      wake_pkt = 1'b1; tick(1); wake_pkt = 1'b0;
      rst_n = 1'b0; tick(2);
      check("R1 out mid reset", wake_out, 1'b0);
      check("R1 oe mid reset", wake_oe, 1'b0);
      rst_n = 1'b1; tick(4);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule